// File: doc/BRIEF.md
# Random Byte Register Port

This block is the software-facing side of a hardware random number generator. It presents three 8-bit registers in a small word-aligned address window: a control/status register, a read-only data register and a mode register. A separate entropy source supplies bytes over a valid/ready handshake. The port takes in one byte whenever the generator is running and its holding register is empty.

Software starts the generator by setting the run bit and writing the run code into the mode register. It then polls the status bit that marks a fresh byte, and reads the data register. That read hands over the byte, empties the holder and zeroes it, so a second read returns zero until a new byte arrives. A software write never changes the fresh-byte flag. Stopping the generator discards any byte that is waiting.

Top module: `rng_byte_port`

## Requirements
- R1: After reset, the control/status register (offset 0x00), the data register (0x04) and the mode register (0x08) all read 0, and `ent_ready` is low.
- R2: The generator runs only when control/status bit 0 is 1 and the mode register holds exactly 0x02. `ent_ready` is high only while it runs and the fresh flag (control/status bit 1) is clear.
- R3: In a cycle where `ent_valid` and `ent_ready` are both high, `ent_byte` is stored. From the next cycle on, the fresh flag reads 1 and `ent_ready` is low.
- R4: A read of offset 0x04 while running with the fresh flag set returns the stored byte in the same cycle. After that cycle the flag is clear and the stored byte is 0.
- R5: A read of offset 0x04 while stopped or while the fresh flag is clear returns 0.
- R6: While stopped, the fresh flag reads 0 and is cleared one cycle later. A byte that was waiting does not return when the generator is restarted.
- R7: A write to offset 0x00 loads bits 7:2 and bit 0 from the low byte of the write data. Bit 1 (the fresh flag) keeps its value. Bits 5:2 act as a prescaler field that is only stored and read back.
- R8: Writes to offset 0x04 have no effect on the stored byte.
- R9: The mode register stores all 8 bits written to offset 0x08 and reads them back.
- R10: Reads at any offset other than 0x00, 0x04 or 0x08, including unaligned ones, return 0. Writes to such offsets change nothing.
- R11: Read data bits 31:8 are always 0, and write data bits 31:8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | DATA_W | Write data, little-endian; only the low byte is used |
| bus_rdata | output | DATA_W | Read data, zero-extended; 0 when no read is strobed |
| ent_valid | input | 1 | Entropy source offers a byte |
| ent_byte | input | 8 | Offered random byte |
| ent_ready | output | 1 | Port will take the offered byte this cycle |

## Verification
A wrong run condition shows in the same cycle on `ent_ready` and on the status read, and a read of the data register returns 0 where it should return a byte. If the flag or the byte is not cleared after a consuming read, the very next data read returns a stale non-zero value and `ent_ready` stays low. A write that reaches the flag, or that corrupts the stored byte, shows on the next status or data read. Bytes from a scrambler-driven stream are matched one by one against what the bench offered. A mismatch there points to a capture taken on the wrong cycle.

// File: rtl/rng_port_pkg.sv
package rng_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  localparam int REG_W      = 8;
  localparam int BIT_RUN    = 0;
  localparam int BIT_FRESH  = 1;
  localparam logic [31:0] OFF_CTRL = 32'h0000_0000;
  localparam logic [31:0] OFF_DATA = 32'h0000_0004;
  localparam logic [31:0] OFF_MODE = 32'h0000_0008;

  // Map a byte offset onto one of the three registers; anything else is none.
  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    reg_sel_e s;
    case (off)
      OFF_CTRL: s = SEL_CTRL;
      OFF_DATA: s = SEL_DATA;
      OFF_MODE: s = SEL_MODE;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

  // The generator runs only with the run bit set and the exact run code.
  function automatic logic is_running(input logic run_bit,
                                      input logic [REG_W-1:0] mode,
                                      input logic [REG_W-1:0] run_code);
    return run_bit && (mode == run_code);
  endfunction

  // Software write to control: every bit taken except the fresh flag.
  function automatic logic [REG_W-1:0] merge_ctrl(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] wr_v);
    logic [REG_W-1:0] keep;
    keep = '0;
    keep[BIT_FRESH] = 1'b1;
    return (wr_v & ~keep) | (old_v & keep);
  endfunction

  // Visible control/status byte: stored bits plus the gated fresh flag.
  function automatic logic [REG_W-1:0] ctrl_view(input logic [REG_W-1:0] stored,
                                                 input logic fresh,
                                                 input logic running);
    logic [REG_W-1:0] v;
    v = stored;
    v[BIT_FRESH] = fresh & running;
    return v;
  endfunction

endpackage

// File: rtl/rng_addr_decode.sv
module rng_addr_decode
  import rng_port_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  logic [31:0] off_ext;

  generate
    if (ADDR_W >= 32) begin : g_trunc
      assign off_ext = addr[31:0];
      logic unused_hi;
      if (ADDR_W > 32) begin : g_hi
        assign unused_hi = ^addr[ADDR_W-1:0];
      end else begin : g_nohi
        assign unused_hi = 1'b0;
      end
    end else begin : g_ext
      assign off_ext = {{(32-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  always_comb sel = decode_offset(off_ext);

endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_port_pkg::*;
#(
  parameter int               W        = 8,
  parameter logic [W-1:0]     RUN_CODE = 8'h02
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic         wr_mode,
  input  logic [W-1:0] wbyte,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] mode_q,
  output logic         running
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= merge_ctrl(ctrl_q, wbyte);
      if (wr_mode) mode_q <= wbyte;
    end
  end

  always_comb running = is_running(ctrl_q[BIT_RUN], mode_q, RUN_CODE);

endmodule

// File: rtl/rng_byte_holder.sv
module rng_byte_holder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         running,
  input  logic         consume_req,
  input  logic         ent_valid,
  input  logic [W-1:0] ent_byte,
  output logic         ent_ready,
  output logic         fresh_q,
  output logic [W-1:0] byte_q,
  output logic         capture_evt,
  output logic         consume_evt
);

  assign ent_ready   = running && !fresh_q;
  assign capture_evt = ent_ready && ent_valid;
  assign consume_evt = consume_req && running && fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      byte_q  <= '0;
    end else if (!running) begin
      fresh_q <= 1'b0;
    end else if (consume_evt) begin
      fresh_q <= 1'b0;
      byte_q  <= '0;
    end else if (capture_evt) begin
      fresh_q <= 1'b1;
      byte_q  <= ent_byte;
    end
  end

endmodule

// File: rtl/rng_read_mux.sv
module rng_read_mux
  import rng_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int DATA_W = 32
) (
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [W-1:0]      ctrl_q,
  input  logic [W-1:0]      mode_q,
  input  logic              fresh_q,
  input  logic [W-1:0]      byte_q,
  input  logic              running,
  output logic [DATA_W-1:0] rdata
);

  logic [W-1:0] val;

  always_comb begin
    case (sel)
      SEL_CTRL: val = ctrl_view(ctrl_q, fresh_q, running);
      SEL_DATA: val = (running && fresh_q) ? byte_q : '0;
      SEL_MODE: val = mode_q;
      default:  val = '0;
    endcase
    rdata = '0;
    if (rd) rdata[W-1:0] = val;
  end

endmodule

// File: rtl/rng_byte_port.sv
module rng_byte_port
  import rng_port_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  RUN_CODE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic [7:0]        ent_byte,
  output logic              ent_ready
);

  localparam int W = REG_W;

  reg_sel_e     sel;
  logic         wr_ctrl, wr_mode, rd_data_req;
  logic [W-1:0] ctrl_q, mode_q, byte_q;
  logic         running, fresh_q, capture_evt, consume_evt;
  logic         unused_upper;

  assign unused_upper = ^bus_wdata[DATA_W-1:W];

  rng_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_ctrl     = bus_wr && (sel == SEL_CTRL);
  assign wr_mode     = bus_wr && (sel == SEL_MODE);
  assign rd_data_req = bus_rd && (sel == SEL_DATA);

  rng_ctrl_regs #(.W(W), .RUN_CODE(RUN_CODE)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_mode (wr_mode),
    .wbyte   (bus_wdata[W-1:0]),
    .ctrl_q  (ctrl_q),
    .mode_q  (mode_q),
    .running (running)
  );

  rng_byte_holder #(.W(W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (running),
    .consume_req (rd_data_req),
    .ent_valid   (ent_valid),
    .ent_byte    (ent_byte),
    .ent_ready   (ent_ready),
    .fresh_q     (fresh_q),
    .byte_q      (byte_q),
    .capture_evt (capture_evt),
    .consume_evt (consume_evt)
  );

  rng_read_mux #(.W(W), .DATA_W(DATA_W)) u_mux (
    .rd      (bus_rd),
    .sel     (sel),
    .ctrl_q  (ctrl_q),
    .mode_q  (mode_q),
    .fresh_q (fresh_q),
    .byte_q  (byte_q),
    .running (running),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/rng_byte_port_chk.sv
module rng_byte_port_chk
  import rng_port_pkg::*;
#(
  parameter int         DATA_W   = 32,
  parameter logic [7:0] RUN_CODE = 8'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [7:0]        ent_byte,
  input logic              ent_ready,
  input reg_sel_e          sel,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        mode_q,
  input logic [7:0]        byte_q,
  input logic              fresh_q,
  input logic              running,
  input logic              capture_evt,
  input logic              consume_evt
);

  // R2
  ready_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> (ctrl_q[0] && mode_q == RUN_CODE));

  // R3
  capture_sets_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (fresh_q && byte_q == $past(ent_byte)));

  // R3
  capture_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> !ent_ready);

  // R4
  consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume_evt |=> (!fresh_q && byte_q == 8'h00));

  // R6
  stop_clears_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !fresh_q);

  // R7
  ctrl_write_keeps_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CTRL && running && !capture_evt && !consume_evt)
      |=> fresh_q == $past(fresh_q));

  // R8
  data_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_DATA && !capture_evt && !consume_evt) |=> $stable(byte_q));

  // R9
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_MODE) |=> mode_q == $past(bus_wdata[7:0]));

  // R10
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_NONE) |-> bus_rdata == '0);

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:8] == '0);

endmodule

bind rng_byte_port rng_byte_port_chk #(.DATA_W(DATA_W), .RUN_CODE(RUN_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .ent_byte    (ent_byte),
  .ent_ready   (ent_ready),
  .sel         (sel),
  .ctrl_q      (ctrl_q),
  .mode_q      (mode_q),
  .byte_q      (byte_q),
  .fresh_q     (fresh_q),
  .running     (running),
  .capture_evt (capture_evt),
  .consume_evt (consume_evt)
);

// File: tb/tb_rng_byte_port.sv
module tb_rng_byte_port;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int WATCHDOG   = 20000;

  // op: 0 idle, 1 read, 2 write
  typedef struct packed {
    logic [1:0]        op;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic              ev;
    logic [7:0]        eb;
    logic [31:0]       exp_rd;
    logic              exp_rdy;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd1, 12'h000, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 4'd1},  // R1 ctrl zero
    '{2'd1, 12'h008, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 4'd1},  // R1 mode zero
    '{2'd1, 12'h004, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 4'd5},  // R5 data zero
    '{2'd2, 12'h000, 32'h1, 1'b0, 8'h00, 32'h00, 1'b0, 4'd2},  // R2 set run bit
    '{2'd1, 12'h000, 32'h0, 1'b0, 8'h00, 32'h01, 1'b0, 4'd2},  // R2 mode 0: stopped
    '{2'd2, 12'h008, 32'h3, 1'b0, 8'h00, 32'h00, 1'b0, 4'd2},  // R2 wrong code
    '{2'd1, 12'h000, 32'h0, 1'b0, 8'h00, 32'h01, 1'b0, 4'd2},  // R2 still stopped
    '{2'd2, 12'h008, 32'h2, 1'b0, 8'h00, 32'h00, 1'b0, 4'd2},  // R2 run code
    '{2'd0, 12'h000, 32'h0, 1'b0, 8'h00, 32'h00, 1'b1, 4'd2},  // R2 ready
    '{2'd1, 12'h000, 32'h0, 1'b0, 8'h00, 32'h01, 1'b1, 4'd2},  // R2 no fresh yet
    '{2'd0, 12'h000, 32'h0, 1'b1, 8'hA5, 32'h00, 1'b1, 4'd3},  // R3 capture A5
    '{2'd1, 12'h000, 32'h0, 1'b1, 8'h3C, 32'h03, 1'b0, 4'd3},  // R3 fresh set
    '{2'd2, 12'h004, 32'h77, 1'b0, 8'h00, 32'h00, 1'b0, 4'd8}, // R8 data write
    '{2'd1, 12'h004, 32'h0, 1'b0, 8'h00, 32'hA5, 1'b0, 4'd4},  // R4 consume
    '{2'd1, 12'h004, 32'h0, 1'b0, 8'h00, 32'h00, 1'b1, 4'd4},  // R4 zeroed
    '{2'd0, 12'h000, 32'h0, 1'b1, 8'h5A, 32'h00, 1'b1, 4'd3},  // R3 capture 5A
    '{2'd2, 12'h000, 32'hFFFF_FFFD, 1'b0, 8'h00, 32'h00, 1'b0, 4'd7}, // R7 write
    '{2'd1, 12'h000, 32'h0, 1'b0, 8'h00, 32'hFF, 1'b0, 4'd7},  // R7 flag kept
    '{2'd2, 12'h000, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 4'd6},  // R6 stop
    '{2'd1, 12'h000, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 4'd6},  // R6 flag hidden
    '{2'd1, 12'h004, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 4'd5},  // R5 stopped read
    '{2'd2, 12'h000, 32'h1, 1'b0, 8'h00, 32'h00, 1'b0, 4'd6},  // R6 restart
    '{2'd1, 12'h000, 32'h0, 1'b0, 8'h00, 32'h01, 1'b1, 4'd6},  // R6 byte lost
    '{2'd1, 12'h004, 32'h0, 1'b0, 8'h00, 32'h00, 1'b1, 4'd5},  // R5 empty read
    '{2'd2, 12'h00C, 32'h12, 1'b0, 8'h00, 32'h00, 1'b1, 4'd10}, // R10 stray write
    '{2'd1, 12'h00C, 32'h0, 1'b0, 8'h00, 32'h00, 1'b1, 4'd10}, // R10 stray read
    '{2'd1, 12'h001, 32'h0, 1'b0, 8'h00, 32'h00, 1'b1, 4'd10}, // R10 unaligned
    '{2'd2, 12'h008, 32'hFFFF_FF81, 1'b0, 8'h00, 32'h00, 1'b1, 4'd9}, // R9 write
    '{2'd1, 12'h008, 32'h0, 1'b0, 8'h00, 32'h81, 1'b0, 4'd11}  // R9 R11 readback
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              ent_valid = 1'b0;
  logic [7:0]        ent_byte = '0;
  logic              ent_ready;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_byte_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ent_valid (ent_valid),
    .ent_byte  (ent_byte),
    .ent_ready (ent_ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, sample before the rising edge.
  task automatic cycle(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic [31:0] wd, input logic ev, input logic [7:0] eb,
                       output logic [31:0] rd, output logic rdy);
    @(negedge clk);
    bus_addr  = a;
    bus_rd    = (op == 2'd1);
    bus_wr    = (op == 2'd2);
    bus_wdata = wd;
    ent_valid = ev;
    ent_byte  = eb;
    #1;
    rd  = bus_rdata;
    rdy = ent_ready;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; ent_valid = 1'b0;
  endtask

  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        rdy;
    logic [7:0]  seed;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready low in reset", {31'b0, ent_ready}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].ev, VECS[i].eb, rd, rdy);
      if (VECS[i].op == 2'd1)
        check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), rd, VECS[i].exp_rd);
      check($sformatf("R%0d vec %0d ready", VECS[i].req, i), {31'b0, rdy},
            {31'b0, VECS[i].exp_rdy});
    end

    // R3 R4: stream of scrambler bytes, each captured and consumed exactly once.
    cycle(2'd2, 12'h008, 32'h2, 1'b0, 8'h00, rd, rdy);
    seed = 8'h1D;
    for (int k = 0; k < 16; k++) begin
      seed = lfsr_next(seed);
      cycle(2'd0, 12'h000, 32'h0, 1'b1, seed, rd, rdy);
      check("R3 stream ready before capture", {31'b0, rdy}, 32'h1);
      cycle(2'd1, 12'h004, 32'h0, 1'b1, ~seed, rd, rdy);
      check("R4 stream byte", rd, {24'h0, seed});
    end

    // R1: reset while a byte is waiting clears everything.
    cycle(2'd0, 12'h000, 32'h0, 1'b1, 8'hC3, rd, rdy);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    cycle(2'd1, 12'h000, 32'h0, 1'b0, 8'h00, rd, rdy);
    check("R1 ctrl after reset", rd, 32'h0);
    check("R1 ready after reset", {31'b0, rdy}, 32'h0);
    cycle(2'd1, 12'h008, 32'h0, 1'b0, 8'h00, rd, rdy);
    check("R1 mode after reset", rd, 32'h0);
    cycle(2'd2, 12'h000, 32'h1, 1'b0, 8'h00, rd, rdy);
    cycle(2'd2, 12'h008, 32'h2, 1'b0, 8'h00, rd, rdy);
    cycle(2'd1, 12'h004, 32'h0, 1'b0, 8'h00, rd, rdy);
    check("R1 data after reset", rd, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule